// File: doc/BRIEF.md
# Prescaled Microsecond Tick Timer

This block is a 32-bit free-running interval timer. An 8-bit prescaler divides the bus clock down to a one-microsecond tick. On each tick the main counter advances by one while counting is enabled. Software sets the period by loading a 32-bit compare value equal to the wanted interval in microseconds. It can choose to have the counter fall back to zero after each match. A 4-bit wrapping count of matches is kept so that software can detect intervals it missed. Each match also produces a single-cycle request pulse, which an external interrupt controller consumes.

Software reaches the block through a small word-addressed register port with per-byte write enables, so single bytes and whole words can both be written. Reads are combinational from the addressed word. To get a 1 µs tick, the prescaler reload is programmed with 256 minus the bus clock frequency in MHz. For example, 252 gives a tick every 4 bus clocks.

Top module: `tick_timer`

## Requirements
- R1: After reset the compare word, the counter word, the control byte and the reload byte all read 0, and `matchIrq` is low.
- R2: While the enable bit (control bit 0) is 1, the counter advances by exactly one every 256−R bus clocks, where R is the reload byte (word 2, bits 15:8). The counter wraps from 0xFFFFFFFF to 0.
- R3: While the enable bit is 0, the counter holds its value.
- R4: With clear-on-match (control bit 1) set, a tick that finds the counter equal to the compare word loads 0. With it clear, the counter moves on past the compare value.
- R5: A tick that finds an enabled counter equal to the compare word drives `matchIrq` high for one cycle, starting in the same cycle as the counter update that tick causes.
- R6: A 4-bit match count increments on every match, wraps from 15 to 0, and reads back in control bits 7:4.
- R7: Writing 1 to control bit 2 zeroes the match count. The bit is not stored and always reads 0.
- R8: A software write to the counter word takes priority over a tick-driven update in the same cycle.
- R9: Word addresses are: 0 compare, 1 counter, 2 control (bits 7:0) plus reload (bits 15:8), and 3 reads as 0. Only the byte lanes whose enable bit is set are written, and lane k covers bits 8k+7:8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Word select |
| busWr | input | 1 | Write strobe |
| busByteEn | input | 4 | Byte lane enables for a write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data of the addressed word |
| matchIrq | output | 1 | One-cycle compare-match pulse |

## Verification
On every cycle, the embedded properties check four things: the prescaler reload after each tick, the counter holding while disabled, the return to zero on a match in clear-on-match mode, and the write-over-tick priority. They also check that each match pulse steps the match count. The bench scenarios show the behaviours that span many cycles: the measured tick spacing for two reload values, the 15-to-0 wrap of the match count, the 32-bit counter wrap, and a counter running past its compare value without a second pulse. The scenarios also cover partial-lane writes and the readback of the self-clearing bit.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int TT_DW    = 32;
  localparam int TT_LANES = TT_DW / 8;
  localparam int TT_OVFW  = 4;

  typedef struct packed {
    logic [TT_LANES-1:0] cmpWr;
    logic [TT_LANES-1:0] cntWr;
    logic                clrOvf;
    logic                tick;
    logic                cntEn;
    logic                clrOnCmp;
  } ttStrobe_t;
endpackage

// File: rtl/tt_ctrl.sv
module tt_ctrl
  import tt_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          busAddr,
  input  logic                busWr,
  input  logic [TT_LANES-1:0] busByteEn,
  input  logic [TT_DW-1:0]    busWrData,
  output ttStrobe_t           strb,
  output logic [PRE_W-1:0]    reload
);
  logic             cntEn, clrOnCmp;
  logic [PRE_W-1:0] presCnt;
  logic             ctrlWr, reloadWr, tick;

  assign ctrlWr   = busWr && (busAddr == 2'd2) && busByteEn[0];
  assign reloadWr = busWr && (busAddr == 2'd2) && busByteEn[1];
  assign tick     = (presCnt == '1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntEn    <= 1'b0;
      clrOnCmp <= 1'b0;
      reload   <= '0;
      presCnt  <= '0;
    end else begin
      if (ctrlWr) begin
        cntEn    <= busWrData[0];
        clrOnCmp <= busWrData[1];
      end
      if (reloadWr) reload <= busWrData[8 +: PRE_W];
      presCnt <= tick ? reload : presCnt + 1'b1;
    end
  end

  always_comb begin
    strb.cmpWr    = (busWr && busAddr == 2'd0) ? busByteEn : '0;
    strb.cntWr    = (busWr && busAddr == 2'd1) ? busByteEn : '0;
    strb.clrOvf   = ctrlWr && busWrData[2];
    strb.tick     = tick;
    strb.cntEn    = cntEn;
    strb.clrOnCmp = clrOnCmp;
  end

  AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> presCnt == $past(reload)); // R2
endmodule

// File: rtl/tt_datapath.sv
module tt_datapath
  import tt_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ttStrobe_t        strb,
  input  logic [TT_DW-1:0] wrData,
  input  logic [1:0]       rdAddr,
  input  logic [PRE_W-1:0] reload,
  output logic [TT_DW-1:0] rdData,
  output logic             matchIrq
);
  logic [TT_DW-1:0]   compare, count, cntNext;
  logic [TT_OVFW-1:0] ovfCnt;
  logic               advance, hit;

  assign advance = strb.tick && strb.cntEn && (strb.cntWr == '0);
  assign hit     = advance && (count == compare);

  always_comb begin
    cntNext = count;
    if (strb.cntWr != '0) begin
      for (int b = 0; b < TT_LANES; b++)
        if (strb.cntWr[b]) cntNext[b*8 +: 8] = wrData[b*8 +: 8];
    end else if (advance) begin
      cntNext = (hit && strb.clrOnCmp) ? '0 : count + 1'b1;
    end
  end

  for (genvar g = 0; g < TT_LANES; g++) begin : gCmpLane
    always_ff @(posedge clk) begin
      if (!rstN) compare[g*8 +: 8] <= '0;
      else if (strb.cmpWr[g]) compare[g*8 +: 8] <= wrData[g*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      ovfCnt   <= '0;
      matchIrq <= 1'b0;
    end else begin
      count    <= cntNext;
      matchIrq <= hit;
      if (strb.clrOvf)  ovfCnt <= '0;
      else if (hit)     ovfCnt <= ovfCnt + 1'b1;
    end
  end

  always_comb begin
    case (rdAddr)
      2'd0:    rdData = compare;
      2'd1:    rdData = count;
      2'd2:    rdData = TT_DW'({reload, ovfCnt, 2'b00, strb.clrOnCmp, strb.cntEn});
      default: rdData = '0;
    endcase
  end

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cntEn && strb.cntWr == '0) |=> $stable(count)); // R3
  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && strb.cntEn && strb.clrOnCmp && strb.cntWr == '0 && count == compare)
      |=> count == '0); // R4
  AST_MATCH_STEPS_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (matchIrq && !$past(strb.clrOvf)) |-> ovfCnt == TT_OVFW'($past(ovfCnt) + 1'b1)); // R6
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntWr == '1) |=> count == $past(wrData)); // R8
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          busAddr,
  input  logic                busWr,
  input  logic [TT_LANES-1:0] busByteEn,
  input  logic [TT_DW-1:0]    busWrData,
  output logic [TT_DW-1:0]    busRdData,
  output logic                matchIrq
);
  ttStrobe_t        strb;
  logic [PRE_W-1:0] reload;

  tt_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busByteEn(busByteEn), .busWrData(busWrData), .strb(strb), .reload(reload)
  );

  tt_datapath #(.PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData), .rdAddr(busAddr),
    .reload(reload), .rdData(busRdData), .matchIrq(matchIrq)
  );
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        matchIrq;
  int          nChecks = 0, nErrors = 0;
  bit          done = 0;

  tick_timer u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busByteEn(busByteEn),
    .busWrData(busWrData), .busRdData(busRdData), .matchIrq(matchIrq)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busByteEn = be; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busByteEn = '0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic cyclesToChange(output int n);
    logic [31:0] v0, v;
    rdReg(2'd1, v0);
    n = 0;
    v = v0;
    while (v == v0 && n < 2000) begin
      @(negedge clk);
      n++;
      rdReg(2'd1, v);
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rdReg(a[1:0], d);
      chk("R1 reset word", d, 32'h0);
    end
    chk("R1 reset irq", {31'b0, matchIrq}, 32'h0);
  endtask

  task automatic testPrescale();
    int n;
    wrReg(2'd0, 4'hF, 32'hFFFF_0000);
    wrReg(2'd1, 4'hF, 32'h0);
    wrReg(2'd2, 4'h3, 32'h0000_FC01);
    cyclesToChange(n);
    cyclesToChange(n);
    chk("R2 period reload 252", n, 4);
    cyclesToChange(n);
    chk("R2 period reload 252 again", n, 4);
    wrReg(2'd2, 4'h3, 32'h0000_FA01);
    cyclesToChange(n);
    cyclesToChange(n);
    cyclesToChange(n);
    chk("R2 period reload 250", n, 6);
  endtask

  task automatic testHold();
    logic [31:0] a, b;
    wrReg(2'd2, 4'h1, 32'h0);
    rdReg(2'd1, a);
    repeat (40) @(negedge clk);
    rdReg(2'd1, b);
    chk("R3 hold while disabled", b, a);
  endtask

  task automatic testClearOnMatch();
    logic [31:0] v, d;
    int pulses = 0, maxV = 0, cyc = 0;
    bit prevIrq = 0, badWidth = 0, badVal = 0;
    wrReg(2'd2, 4'h2, 32'h0000_FC00);
    wrReg(2'd1, 4'hF, 32'h0);
    wrReg(2'd0, 4'hF, 32'd5);
    wrReg(2'd2, 4'h1, 32'h3);
    while (pulses < 17 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      rdReg(2'd1, v);
      if (int'(v) > maxV) maxV = int'(v);
      if (matchIrq) begin
        pulses++;
        if (prevIrq) badWidth = 1;
        if (v != 0) badVal = 1;
      end
      prevIrq = matchIrq;
    end
    wrReg(2'd2, 4'h1, 32'h0);
    chk("R5 seventeen pulses seen", pulses, 17);
    chk("R4 counter never above compare", maxV, 5);
    chk("R4 counter zero at match", {31'b0, badVal}, 0);
    chk("R5 pulse one cycle wide", {31'b0, badWidth}, 0);
    rdReg(2'd2, d);
    chk("R6 match count wrapped to 1", d[7:4], 1);
    wrReg(2'd2, 4'h1, 32'h4);
    rdReg(2'd2, d);
    chk("R7 clear count, bit2 reads 0", d[7:0], 0);
  endtask

  task automatic testRunPastAndWrap();
    logic [31:0] v;
    int pulses = 0, cyc = 0;
    logic [31:0] atIrq = '1;
    wrReg(2'd0, 4'hF, 32'd5);
    wrReg(2'd1, 4'hF, 32'd3);
    wrReg(2'd2, 4'h1, 32'h1);
    v = 3;
    while (v < 8 && cyc < 500) begin
      @(negedge clk);
      cyc++;
      rdReg(2'd1, v);
      if (matchIrq) begin pulses++; atIrq = v; end
    end
    chk("R4 runs past compare", {31'b0, v >= 8}, 1);
    chk("R5 single pulse", pulses, 1);
    chk("R5 counter value with pulse", atIrq, 6);
    wrReg(2'd1, 4'hF, 32'hFFFF_FFFE);
    begin
      int n;
      cyclesToChange(n);
      rdReg(2'd1, v);
      chk("R2 reaches all ones", v, 32'hFFFF_FFFF);
      cyclesToChange(n);
      rdReg(2'd1, v);
      chk("R2 wraps to zero", v, 0);
    end
  endtask

  task automatic testPriority();
    logic [31:0] v;
    wrReg(2'd0, 4'hF, 32'hFFFF_0000);
    wrReg(2'd2, 4'h3, 32'h0000_FF01);
    repeat (10) @(negedge clk);
    wrReg(2'd1, 4'hF, 32'h0000_1234);
    rdReg(2'd1, v);
    chk("R8 write beats tick", v, 32'h0000_1234);
    @(negedge clk);
    rdReg(2'd1, v);
    chk("R2 tick every clock at reload 255", v, 32'h0000_1235);
    wrReg(2'd2, 4'h1, 32'h0);
  endtask

  task automatic testLanes();
    logic [31:0] v;
    wrReg(2'd0, 4'hF, 32'hAABB_CCDD);
    wrReg(2'd0, 4'h4, 32'h0055_0000);
    rdReg(2'd0, v);
    chk("R9 single lane write", v, 32'hAA55_CCDD);
    wrReg(2'd3, 4'hF, 32'hFFFF_FFFF);
    rdReg(2'd3, v);
    chk("R9 word 3 reads zero", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPrescale();
    testHold();
    testClearOnMatch();
    testRunPastAndWrap();
    testPriority();
    testLanes();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule